// File: doc/BRIEF.md
# Regulator Sequencing and Fault Supervisor

This block is the digital supervisor of a switching regulator. It sees clean digital flags from the analog front end: two supply-rail good flags, the enable input, a soft-start-complete flag, raw under-voltage and over-voltage comparator outputs, an over-current event strobe and an over-temperature flag. From these it decides whether the power stage may switch (`run_o`), whether the soft-start ramp must be held at zero (`ss_discharge_o`), whether both gates must be tri-stated (`gate_hiz_o`), and whether the output is declared good (`pgood_o`, where 0 means the open-drain pin is driven low).

Enable-ready is the AND of both rail flags and the enable input. Losing it always returns the supervisor to its off state, and it is the only way to clear the latched faults and the over-current strike count. The two voltage comparators pass through saturating-counter filters sized from a filter time and the clock period. An under-voltage pulls power-good low and nothing else. An over-voltage latches a shutdown. Over-current events cause a soft-start restart, and the strike that reaches the limit latches switching off. Over-temperature stops switching until the flag clears and then resumes without a new soft-start.

States: `ST_OFF` (idle), `ST_RUN` (switching), `ST_DISCH` (soft-start restart after an over-current event), `ST_THERM` (thermal stop), `ST_OV_LOCK` (latched over-voltage) and `ST_OC_LOCK` (latched over-current). Transitions: any state goes to OFF when enable-ready is low. OFF goes to RUN when enable-ready is high. RUN goes to OV_LOCK on the filtered over-voltage; otherwise to OC_LOCK or DISCH on an over-current event; otherwise to THERM on over-temperature. DISCH goes to OV_LOCK on over-voltage, else to RUN once soft-start-complete is low. THERM goes to OV_LOCK on over-voltage, else to RUN once over-temperature is low. The two lock states are left only through OFF.

Top module: `reg_seq_supervisor`

## Requirements
- R1: After reset the outputs are run_o=0, gate_hiz_o=1, ss_discharge_o=1 and pgood_o=0.
- R2: With vcc_ok, ldo_ok and en_in all 1 at a clock edge, an OFF supervisor is switching (run_o=1, gate_hiz_o=0, ss_discharge_o=0) after that edge. If any of the three is 0 at an edge, the supervisor is in OFF after that edge.
- R3: pgood_o is 1 only while switching (run_o=1), ss_done=1, and neither filtered voltage fault is active; it follows ss_done in the same cycle.
- R4: A voltage flag takes effect only once it has been sampled high on FILT_CYCLES consecutive edges (18 with the defaults of 350 ns at 20 ns). A shorter pulse has no effect on any output.
- R5: A filtered under-voltage drives pgood_o to 0 while run_o stays 1 and gate_hiz_o stays 0.
- R6: A filtered over-voltage moves the supervisor to a latched shutdown (run_o=0, gate_hiz_o=1, ss_discharge_o=1, pgood_o=0) on the next edge. The shutdown persists after ov_raw clears, until enable-ready goes low.
- R7: An over-current event while switching, unless it is the last allowed strike, gives gate_hiz_o=1, ss_discharge_o=1, run_o=0 after the next edge. Switching resumes on the edge after ss_done is sampled 0.
- R8: The OC_LIMIT-th (4th) counted over-current event latches switching off (run_o=0, gate_hiz_o=1, ss_discharge_o=1) until enable-ready goes low. Enable-ready low also clears the strike count, so the next three events cause only restarts.
- R9: Over-temperature while switching gives gate_hiz_o=1, pgood_o=0, ss_discharge_o=0 after the next edge. Switching resumes on the edge after ot_flag is sampled 0.
- R10: Over-current strobes that arrive while not switching, for example during a thermal stop, are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_ok | input | 1 | Gate-drive supply within range |
| ldo_ok | input | 1 | Internal low-voltage rail within range |
| en_in | input | 1 | Enable input above its threshold |
| ss_done | input | 1 | Soft-start ramp has reached its ready level |
| uv_raw | input | 1 | Unfiltered output under-voltage comparator |
| ov_raw | input | 1 | Unfiltered output over-voltage comparator |
| oc_evt | input | 1 | Over-current detected in this cycle (strobe) |
| ot_flag | input | 1 | Over-temperature (hysteresis applied upstream) |
| run_o | output | 1 | Power stage may switch |
| ss_discharge_o | output | 1 | Hold the soft-start ramp at zero |
| gate_hiz_o | output | 1 | Tri-state both power gates |
| pgood_o | output | 1 | 1 releases the power-good pin, 0 drives it low |

## Verification
A state change caused by enable, an over-current strobe, over-temperature or soft-start-complete is due one edge after the input is presented. A voltage fault adds the filter: power-good responds right after the 18th consecutive high sample, and the state changes one edge later. Power-good follows ss_done with no register. The bench drives inputs at the falling edge, advances its reference model on the rising edge, and compares all four outputs at the next falling edge, before any input moves. Every cycle's result is therefore read at the instant it is due.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_RUN     = 3'd1,
        ST_DISCH   = 3'd2,
        ST_THERM   = 3'd3,
        ST_OV_LOCK = 3'd4,
        ST_OC_LOCK = 3'd5
    } sup_state_t;

    // Number of whole clock cycles covering a time span (rounded up).
    function automatic int unsigned span_cycles(input int unsigned span_ns,
                                                input int unsigned period_ns);
        return (span_ns + period_ns - 1) / period_ns;
    endfunction

endpackage

// File: rtl/sup_filter.sv
// Persistence filter: output rises after DEPTH consecutive high samples,
// falls on the first low sample.
module sup_filter #(
    parameter int unsigned DEPTH = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int unsigned W = $clog2(DEPTH + 1);
    localparam logic [W-1:0] TOP = W'(DEPTH);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!raw) begin
            cnt <= '0;
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign filt = (cnt == TOP);
endmodule

// File: rtl/sup_strike_ctr.sv
// Saturating count of over-current strikes; cleared while enable-ready is low.
module sup_strike_ctr #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic hit,
    output logic last
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP  = W'(LIMIT);
    localparam logic [W-1:0] PREV = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (hit && cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Next counted strike is the one that reaches the limit.
    assign last = (cnt == PREV);
endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
    import sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_ready,
    input  logic       ss_done,
    input  logic       uv_f,
    input  logic       ov_f,
    input  logic       oc_evt,
    input  logic       ot_flag,
    input  logic       oc_last,
    output sup_state_t state,
    output logic       oc_hit,
    output logic       run_o,
    output logic       ss_discharge_o,
    output logic       gate_hiz_o,
    output logic       pgood_o
);
    sup_state_t nxt;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    // Transition logic; loss of enable-ready wins over everything.
    always_comb begin
        nxt = state;
        if (!en_ready) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: nxt = ST_RUN;
                ST_RUN: begin
                    if (ov_f)         nxt = ST_OV_LOCK;
                    else if (oc_evt)  nxt = oc_last ? ST_OC_LOCK : ST_DISCH;
                    else if (ot_flag) nxt = ST_THERM;
                end
                ST_DISCH: begin
                    if (ov_f)          nxt = ST_OV_LOCK;
                    else if (!ss_done) nxt = ST_RUN;
                end
                ST_THERM: begin
                    if (ov_f)          nxt = ST_OV_LOCK;
                    else if (!ot_flag) nxt = ST_RUN;
                end
                ST_OV_LOCK: nxt = ST_OV_LOCK;
                ST_OC_LOCK: nxt = ST_OC_LOCK;
                default:    nxt = ST_OFF;
            endcase
        end
    end

    assign oc_hit = (state == ST_RUN) && oc_evt && en_ready;

    // Output decode.
    always_comb begin
        run_o          = 1'b0;
        ss_discharge_o = 1'b1;
        gate_hiz_o     = 1'b1;
        pgood_o        = 1'b0;
        unique case (state)
            ST_RUN: begin
                run_o          = 1'b1;
                ss_discharge_o = 1'b0;
                gate_hiz_o     = 1'b0;
                pgood_o        = ss_done && !uv_f && !ov_f;
            end
            ST_THERM: begin
                ss_discharge_o = 1'b0;
            end
            ST_OFF, ST_DISCH, ST_OV_LOCK, ST_OC_LOCK: begin
                ss_discharge_o = 1'b1;
            end
            default: begin
                ss_discharge_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/reg_seq_supervisor.sv
module reg_seq_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned FILTER_NS     = 350,
    parameter int unsigned OC_LIMIT      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok,
    input  logic ldo_ok,
    input  logic en_in,
    input  logic ss_done,
    input  logic uv_raw,
    input  logic ov_raw,
    input  logic oc_evt,
    input  logic ot_flag,
    output logic run_o,
    output logic ss_discharge_o,
    output logic gate_hiz_o,
    output logic pgood_o
);
    localparam int unsigned FILT_CYCLES = span_cycles(FILTER_NS, CLK_PERIOD_NS);
    localparam int unsigned NFLAG       = 2;   // 0: under-voltage, 1: over-voltage

    logic             en_ready;
    logic [NFLAG-1:0] flag_raw;
    logic [NFLAG-1:0] flag_f;
    logic             uv_f;
    logic             ov_f;
    logic             oc_last;
    logic             oc_hit;
    sup_state_t       state;

    assign en_ready = vcc_ok && ldo_ok && en_in;
    assign flag_raw = {ov_raw, uv_raw};

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_filt
        sup_filter #(.DEPTH(FILT_CYCLES)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (flag_raw[gi]),
            .filt (flag_f[gi])
        );
    end

    assign uv_f = flag_f[0];
    assign ov_f = flag_f[1];

    sup_strike_ctr #(.LIMIT(OC_LIMIT)) u_strike (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(!en_ready),
        .hit  (oc_hit),
        .last (oc_last)
    );

    sup_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_ready      (en_ready),
        .ss_done       (ss_done),
        .uv_f          (uv_f),
        .ov_f          (ov_f),
        .oc_evt        (oc_evt),
        .ot_flag       (ot_flag),
        .oc_last       (oc_last),
        .state         (state),
        .oc_hit        (oc_hit),
        .run_o         (run_o),
        .ss_discharge_o(ss_discharge_o),
        .gate_hiz_o    (gate_hiz_o),
        .pgood_o       (pgood_o)
    );
endmodule

// File: rtl/sup_checker.sv
module sup_checker
    import sup_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       vcc_ok,
    input logic       ldo_ok,
    input logic       en_in,
    input logic       ss_done,
    input logic       ov_raw,
    input logic       oc_evt,
    input logic       ot_flag,
    input logic       uv_f,
    input logic       ov_f,
    input sup_state_t state,
    input logic       run_o,
    input logic       ss_discharge_o,
    input logic       gate_hiz_o,
    input logic       pgood_o
);
    logic en_rdy;
    assign en_rdy = vcc_ok && ldo_ok && en_in;

    a_r2_en_drop_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_rdy |=> (state == ST_OFF));

    a_r3_pgood_gated: assert property (@(posedge clk) disable iff (!rst_n)
        pgood_o |-> (run_o && ss_done));

    a_r4_ov_filtered: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ov_f) |-> $past(ov_raw));

    a_r5_uv_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && en_rdy && uv_f && !ov_f && !oc_evt && !ot_flag) |=> run_o);

    a_r6_ov_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OV_LOCK && en_rdy) |=> (state == ST_OV_LOCK));

    a_r7_disch_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISCH) |-> (ss_discharge_o && gate_hiz_o && !run_o));

    a_r8_oc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OC_LOCK && en_rdy) |=> (state == ST_OC_LOCK));

    a_r9_therm_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_THERM) |-> (gate_hiz_o && !pgood_o && !ss_discharge_o));
endmodule

bind reg_seq_supervisor sup_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .vcc_ok        (vcc_ok),
    .ldo_ok        (ldo_ok),
    .en_in         (en_in),
    .ss_done       (ss_done),
    .ov_raw        (ov_raw),
    .oc_evt        (oc_evt),
    .ot_flag       (ot_flag),
    .uv_f          (uv_f),
    .ov_f          (ov_f),
    .state         (state),
    .run_o         (run_o),
    .ss_discharge_o(ss_discharge_o),
    .gate_hiz_o    (gate_hiz_o),
    .pgood_o       (pgood_o)
);

// File: tb/sim_reg_seq_supervisor.sv
module sim_reg_seq_supervisor;
    localparam int FILT = 18;
    localparam int LIM  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_ok = 0, ldo_ok = 0, en_in = 0, ss_done = 0;
    logic uv_raw = 0, ov_raw = 0, oc_evt = 0, ot_flag = 0;
    logic run_o, ss_discharge_o, gate_hiz_o, pgood_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    string phase = "R1 reset";

    always #10 clk = ~clk;

    reg_seq_supervisor u0 (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .ldo_ok(ldo_ok), .en_in(en_in),
        .ss_done(ss_done), .uv_raw(uv_raw), .ov_raw(ov_raw), .oc_evt(oc_evt),
        .ot_flag(ot_flag), .run_o(run_o), .ss_discharge_o(ss_discharge_o),
        .gate_hiz_o(gate_hiz_o), .pgood_o(pgood_o)
    );

    // Reference model: 0 off, 1 run, 2 restart, 3 thermal, 4 ov latch, 5 oc latch
    int m_st = 0, m_cnt = 0, m_uvc = 0, m_ovc = 0;

    function automatic int next_state(int st, bit enr, bit ovf, bit oc, bit ot,
                                      bit ssd, int cnt);
        if (!enr) return 0;
        case (st)
            0: return 1;
            1: if (ovf) return 4; else if (oc) return (cnt == LIM-1) ? 5 : 2;
               else if (ot) return 3; else return 1;
            2: if (ovf) return 4; else if (!ssd) return 1; else return 2;
            3: if (ovf) return 4; else if (!ot) return 1; else return 3;
            default: return st;
        endcase
    endfunction

    function automatic bit exp_pgood(int st, bit ssd, int uvc, int ovc);
        return (st == 1) && ssd && (uvc != FILT) && (ovc != FILT);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_uvc = 0; m_ovc = 0;
        end else begin
            automatic bit enr = vcc_ok && ldo_ok && en_in;
            automatic int ns = next_state(m_st, enr, m_ovc == FILT, oc_evt, ot_flag,
                                          ss_done, m_cnt);
            if (!enr) m_cnt = 0;
            else if (m_st == 1 && oc_evt && m_cnt < LIM) m_cnt++;
            m_uvc = !uv_raw ? 0 : (m_uvc < FILT ? m_uvc + 1 : m_uvc);
            m_ovc = !ov_raw ? 0 : (m_ovc < FILT ? m_ovc + 1 : m_ovc);
            m_st = ns;
        end
    end

    task automatic cmp(string what, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (t=%0t)", phase, what, act, exp, $time);
        end
    endtask

    task automatic check_model();
        cmp("run_o", run_o, m_st == 1);
        cmp("gate_hiz_o", gate_hiz_o, m_st != 1);
        cmp("ss_discharge_o", ss_discharge_o, m_st == 0 || m_st == 2 || m_st >= 4);
        cmp("pgood_o", pgood_o, exp_pgood(m_st, ss_done, m_uvc, m_ovc));
    endtask

    task automatic check_lit(logic r, logic h, logic d, logic p);
        cmp("run_o(direct)", run_o, r);
        cmp("gate_hiz_o(direct)", gate_hiz_o, h);
        cmp("ss_discharge_o(direct)", ss_discharge_o, d);
        cmp("pgood_o(direct)", pgood_o, p);
    endtask

    // Advance n cycles; compare with the model at each falling edge.
    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_model();
        end
    endtask

    task automatic oc_pulse();
        oc_evt = 1; step(1); oc_evt = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        automatic int unsigned seed = $urandom(32'd4242);
        seed = seed;
        repeat (2) @(negedge clk);
        rst_n = 1;
        step(2);
        phase = "R1 reset";
        check_lit(0, 1, 1, 0);

        phase = "R2 enable gating";
        vcc_ok = 1; ldo_ok = 1; step(3);
        check_lit(0, 1, 1, 0);
        en_in = 1; step(1);
        check_lit(1, 0, 0, 0);
        ldo_ok = 0; step(1);
        check_lit(0, 1, 1, 0);
        ldo_ok = 1; step(2);

        phase = "R3 pgood";
        ss_done = 1; step(0);
        @(negedge clk); #1;
        check_lit(1, 0, 0, 1);
        step(2);

        phase = "R4 short uv pulse";
        uv_raw = 1; step(FILT - 1); uv_raw = 0; step(1);
        check_lit(1, 0, 0, 1);
        phase = "R5 uv keeps switching";
        uv_raw = 1; step(FILT);
        check_lit(1, 0, 0, 0);
        step(6);
        check_lit(1, 0, 0, 0);
        uv_raw = 0; step(2);

        phase = "R6 ov latch";
        ov_raw = 1; step(FILT + 1);
        check_lit(0, 1, 1, 0);
        ov_raw = 0; step(5);
        check_lit(0, 1, 1, 0);
        en_in = 0; step(2); en_in = 1; step(2);
        check_lit(1, 0, 0, 1);

        phase = "R7 oc restart";
        oc_pulse();
        check_lit(0, 1, 1, 0);
        step(3);
        ss_done = 0; step(1);
        check_lit(1, 0, 0, 0);
        step(2); ss_done = 1; step(2);

        phase = "R9 thermal stop";
        ot_flag = 1; step(1);
        check_lit(0, 1, 0, 0);
        phase = "R10 oc ignored off-run";
        oc_pulse(); step(1); oc_pulse(); oc_pulse(); step(2);
        phase = "R9 thermal resume";
        ot_flag = 0; step(1);
        check_lit(1, 0, 0, 1);

        phase = "R10 strikes two and three";
        for (int k = 0; k < 2; k++) begin
            oc_pulse(); step(1); ss_done = 0; step(1); ss_done = 1; step(2);
        end
        check_lit(1, 0, 0, 1);
        phase = "R8 fourth strike latches";
        oc_pulse();
        check_lit(0, 1, 1, 0);
        ss_done = 0; step(4); ss_done = 1; step(2);
        check_lit(0, 1, 1, 0);
        vcc_ok = 0; step(1); vcc_ok = 1; step(2);
        phase = "R8 count cleared";
        for (int k = 0; k < 3; k++) begin
            oc_pulse(); step(1); ss_done = 0; step(1); ss_done = 1; step(2);
        end
        check_lit(1, 0, 0, 1);

        phase = "random mix";
        for (int c = 0; c < 6000; c++) begin
            vcc_ok  = ($urandom % 400) != 0;
            ldo_ok  = ($urandom % 400) != 0;
            en_in   = ($urandom % 300) != 0;
            oc_evt  = ($urandom % 50) == 0;
            if ($urandom % 12 == 0)  ss_done = ~ss_done;
            if ($urandom % 25 == 0)  uv_raw  = ~uv_raw;
            if ($urandom % 200 == 0) ov_raw  = ~ov_raw;
            if ($urandom % 60 == 0)  ot_flag = ~ot_flag;
            step(1);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule